// File: doc/BRIEF.md
# MII Nibble Loopback Multiplexer

This block sits between a MAC's nibble-wide transmit/receive ports and the Media Independent Interface data pins of an external PHY. In normal operation the receive bundle (data, data-valid, receive error, receive clock, carrier sense) reaches the MAC unchanged from the PHY pins. In internal loopback the MAC's own transmit nibbles, transmit enable and transmit clock are turned around onto its receive side. Everything arriving from the PHY receive pins is then ignored. The transmit pins keep carrying the transmitted frame throughout.

Loopback is granted only when three conditions all hold: software requests it, every other port loopback mode is off, and the MII port was selected manually. The grant passes through a short synchroniser. The active mode changes only while both transmit enable and the PHY's receive data-valid are low, so a frame in flight is never cut. During loopback, carrier sense is the OR of transmit enable and the looped data-valid, so it spans the whole transmitted frame. The transmit-error pin is never driven high and is not looped; the receive error seen by the MAC stays low in loopback.

Top module: `mii_loopback_mux`

## Requirements
- R1: After reset the block is in normal mode, and the MAC receive outputs follow the PHY receive pins.
- R2: In loopback, mac_rxd_o equals mac_txd_i bit for bit, in the same cycle, whatever arrives on phy_rxd_i.
- R3: In loopback, mac_rx_clk_o follows phy_tx_clk_i. In normal mode it follows phy_rx_clk_i. mac_tx_clk_o always follows phy_tx_clk_i.
- R4: In loopback, mac_rx_dv_o equals mac_tx_enable (mac_tx_en_i), and phy_rx_dv_i is ignored.
- R5: In loopback, mac_crs_o is the OR of mac_tx_en_i and the looped data-valid, so it is high on every cycle of transmit enable. In normal mode it follows phy_crs_i.
- R6: In loopback, mac_rx_er_o is 0 whatever arrives on phy_rx_er_i. In normal mode it follows phy_rx_er_i.
- R7: phy_txd_o and phy_tx_en_o always equal mac_txd_i and mac_tx_en_i, in either mode. phy_tx_er_o is always 0.
- R8: Loopback is engaged only when lb_req_i, other_lb_off_i and manual_sel_i are all 1. If any of them is 0, the target mode is normal.
- R9: The active mode changes only on a clock edge where mac_tx_en_i and phy_rx_dv_i were both low. When the target mode changes and the interface is quiet, the new mode takes effect after SYNC_STAGES+1 rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock for mode control |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lb_req_i | input | 1 | Software request for internal MII loopback |
| other_lb_off_i | input | 1 | High when all other port loopback modes are off |
| manual_sel_i | input | 1 | High when the MII port was selected manually |
| mac_txd_i | input | 4 | MAC transmit nibble |
| mac_tx_en_i | input | 1 | MAC transmit enable |
| mac_tx_clk_o | output | 1 | Transmit clock to MAC |
| mac_rxd_o | output | 4 | Receive nibble to MAC |
| mac_rx_dv_o | output | 1 | Receive data-valid to MAC |
| mac_rx_er_o | output | 1 | Receive error to MAC |
| mac_rx_clk_o | output | 1 | Receive clock to MAC |
| mac_crs_o | output | 1 | Carrier sense to MAC |
| phy_txd_o | output | 4 | Transmit nibble pins |
| phy_tx_en_o | output | 1 | Transmit enable pin |
| phy_tx_er_o | output | 1 | Transmit error pin, held low |
| phy_tx_clk_i | input | 1 | Transmit clock from PHY |
| phy_rxd_i | input | 4 | Receive nibble pins |
| phy_rx_dv_i | input | 1 | Receive data-valid pin |
| phy_rx_er_i | input | 1 | Receive error pin |
| phy_rx_clk_i | input | 1 | Receive clock from PHY |
| phy_crs_i | input | 1 | Carrier sense pin |

## Verification
The risky overlap is a change of the loopback request arriving in the same cycle as frame activity. This covers both a transmit frame in loopback and a PHY receive frame in normal mode. The bench raises or drops the request while mac_tx_en_i or phy_rx_dv_i is held high, and with the PHY pins carrying values that differ from the transmit side. It first checks that the receive outputs keep following the old source for the whole active stretch. Once both enables fall, it checks that the new source is selected after the synchroniser latency.

// File: rtl/mii_lb_pkg.sv
package mii_lb_pkg;
  localparam int unsigned NIBBLE_W = 4;

  typedef struct packed {
    logic [NIBBLE_W-1:0] rxd;
    logic                rx_dv;
    logic                rx_er;
    logic                rx_clk;
  } mii_rx_t;
endpackage

// File: rtl/mii_lb_mode_ctrl.sv
module mii_lb_mode_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic other_lb_off_i,
  input  logic manual_sel_i,
  input  logic tx_en_i,
  input  logic rx_dv_i,
  output logic loop_o
);
  logic eligible;
  logic target;
  logic quiet;
  logic mode_q;
  logic [SYNC_STAGES-1:0] sync_q;

  assign eligible = req_i & other_lb_off_i & manual_sel_i;
  assign quiet    = ~tx_en_i & ~rx_dv_i;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= eligible;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], eligible};
      end
    end
  endgenerate

  assign target = sync_q[SYNC_STAGES-1];

  // mode flips only between frames
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= 1'b0;
    else if (quiet) mode_q <= target;
  end

  assign loop_o = mode_q;

  a_r9_switch_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> $past(!tx_en_i && !rx_dv_i));
  a_r8_engage_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q) |-> $past(target));
endmodule

// File: rtl/mii_lb_rx_mux.sv
module mii_lb_rx_mux
  import mii_lb_pkg::*;
(
  input  logic    loop_i,
  input  mii_rx_t phy_rx_i,
  input  mii_rx_t lb_rx_i,
  output mii_rx_t mac_rx_o
);
  generate
    for (genvar b = 0; b < NIBBLE_W; b++) begin : g_bit
      assign mac_rx_o.rxd[b] = loop_i ? lb_rx_i.rxd[b] : phy_rx_i.rxd[b];
    end
  endgenerate

  assign mac_rx_o.rx_dv  = loop_i ? lb_rx_i.rx_dv  : phy_rx_i.rx_dv;
  assign mac_rx_o.rx_er  = loop_i ? lb_rx_i.rx_er  : phy_rx_i.rx_er;
  assign mac_rx_o.rx_clk = loop_i ? lb_rx_i.rx_clk : phy_rx_i.rx_clk;
endmodule

// File: rtl/mii_lb_crs_gen.sv
module mii_lb_crs_gen (
  input  logic loop_i,
  input  logic tx_en_i,
  input  logic rx_dv_i,
  input  logic phy_crs_i,
  output logic crs_o
);
  // loop carrier spans the full transmit frame
  assign crs_o = loop_i ? (tx_en_i | rx_dv_i) : phy_crs_i;
endmodule

// File: rtl/mii_loopback_mux.sv
module mii_loopback_mux
  import mii_lb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lb_req_i,
  input  logic                other_lb_off_i,
  input  logic                manual_sel_i,
  input  logic [NIBBLE_W-1:0] mac_txd_i,
  input  logic                mac_tx_en_i,
  output logic                mac_tx_clk_o,
  output logic [NIBBLE_W-1:0] mac_rxd_o,
  output logic                mac_rx_dv_o,
  output logic                mac_rx_er_o,
  output logic                mac_rx_clk_o,
  output logic                mac_crs_o,
  output logic [NIBBLE_W-1:0] phy_txd_o,
  output logic                phy_tx_en_o,
  output logic                phy_tx_er_o,
  input  logic                phy_tx_clk_i,
  input  logic [NIBBLE_W-1:0] phy_rxd_i,
  input  logic                phy_rx_dv_i,
  input  logic                phy_rx_er_i,
  input  logic                phy_rx_clk_i,
  input  logic                phy_crs_i
);
  logic    loop;
  mii_rx_t phy_rx;
  mii_rx_t lb_rx;
  mii_rx_t mac_rx;

  mii_lb_mode_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_i          (lb_req_i),
    .other_lb_off_i (other_lb_off_i),
    .manual_sel_i   (manual_sel_i),
    .tx_en_i        (mac_tx_en_i),
    .rx_dv_i        (phy_rx_dv_i),
    .loop_o         (loop)
  );

  assign phy_rx = '{rxd: phy_rxd_i, rx_dv: phy_rx_dv_i, rx_er: phy_rx_er_i, rx_clk: phy_rx_clk_i};
  // transmit error is never looped
  assign lb_rx  = '{rxd: mac_txd_i, rx_dv: mac_tx_en_i, rx_er: 1'b0, rx_clk: phy_tx_clk_i};

  mii_lb_rx_mux u_rx_mux (
    .loop_i   (loop),
    .phy_rx_i (phy_rx),
    .lb_rx_i  (lb_rx),
    .mac_rx_o (mac_rx)
  );

  mii_lb_crs_gen u_crs (
    .loop_i    (loop),
    .tx_en_i   (mac_tx_en_i),
    .rx_dv_i   (mac_rx.rx_dv),
    .phy_crs_i (phy_crs_i),
    .crs_o     (mac_crs_o)
  );

  assign mac_rxd_o    = mac_rx.rxd;
  assign mac_rx_dv_o  = mac_rx.rx_dv;
  assign mac_rx_er_o  = mac_rx.rx_er;
  assign mac_rx_clk_o = mac_rx.rx_clk;
  assign mac_tx_clk_o = phy_tx_clk_i;
  assign phy_txd_o    = mac_txd_i;
  assign phy_tx_en_o  = mac_tx_en_i;
  assign phy_tx_er_o  = 1'b0;

  a_r5_crs_covers_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop && mac_tx_en_i) |-> mac_crs_o);
  a_r6_no_rx_err_loop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop |-> !mac_rx_er_o);
  a_r4_dv_tracks_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop |-> (mac_rx_dv_o == phy_tx_en_o));
  a_r2_data_loops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop |-> (mac_rxd_o == phy_txd_o));
endmodule

// File: tb/tb_mii_loopback_mux.sv
module tb_mii_loopback_mux;
  import mii_lb_pkg::*;

  localparam int unsigned SYNC = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic lb_req = 0, other_off = 0, manual = 0;
  logic [3:0] mac_txd = '0;
  logic mac_tx_en = 0;
  logic mac_tx_clk, mac_rx_dv, mac_rx_er, mac_rx_clk, mac_crs;
  logic [3:0] mac_rxd, phy_txd;
  logic phy_tx_en, phy_tx_er;
  logic phy_tx_clk = 0, phy_rx_dv = 0, phy_rx_er = 0, phy_rx_clk = 0, phy_crs = 0;
  logic [3:0] phy_rxd = '0;

  int checks = 0;
  int fails  = 0;
  bit exp_loop = 0;

  always #2.5 clk = ~clk;

  mii_loopback_mux #(.SYNC_STAGES(SYNC)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lb_req_i(lb_req), .other_lb_off_i(other_off), .manual_sel_i(manual),
    .mac_txd_i(mac_txd), .mac_tx_en_i(mac_tx_en), .mac_tx_clk_o(mac_tx_clk),
    .mac_rxd_o(mac_rxd), .mac_rx_dv_o(mac_rx_dv), .mac_rx_er_o(mac_rx_er),
    .mac_rx_clk_o(mac_rx_clk), .mac_crs_o(mac_crs),
    .phy_txd_o(phy_txd), .phy_tx_en_o(phy_tx_en), .phy_tx_er_o(phy_tx_er),
    .phy_tx_clk_i(phy_tx_clk), .phy_rxd_i(phy_rxd), .phy_rx_dv_i(phy_rx_dv),
    .phy_rx_er_i(phy_rx_er), .phy_rx_clk_i(phy_rx_clk), .phy_crs_i(phy_crs)
  );

  function automatic logic [3:0] f_rxd(bit lp);
    return lp ? mac_txd : phy_rxd;
  endfunction
  function automatic logic f_dv(bit lp);
    return lp ? mac_tx_en : phy_rx_dv;
  endfunction
  function automatic logic f_crs(bit lp);
    return lp ? (mac_tx_en | mac_tx_en) : phy_crs;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // compare every output against the model for the expected mode
  task automatic chk_all(bit lp);
    chk("R2 rxd", {4'h0, mac_rxd}, {4'h0, f_rxd(lp)});
    chk("R4 rx_dv", {7'h0, mac_rx_dv}, {7'h0, f_dv(lp)});
    chk("R5 crs", {7'h0, mac_crs}, {7'h0, f_crs(lp)});
    chk("R6 rx_er", {7'h0, mac_rx_er}, {7'h0, lp ? 1'b0 : phy_rx_er});
    chk("R3 rx_clk", {7'h0, mac_rx_clk}, {7'h0, lp ? phy_tx_clk : phy_rx_clk});
    chk("R3 tx_clk", {7'h0, mac_tx_clk}, {7'h0, phy_tx_clk});
    chk("R7 tx pins", {2'b0, phy_tx_er, phy_tx_en, phy_txd}, {3'b0, mac_tx_en, mac_txd});
  endtask

  task automatic noise();
    phy_rxd = 4'($urandom); phy_rx_er = 1'($urandom);
    phy_crs = 1'($urandom); phy_tx_clk = 1'($urandom); phy_rx_clk = 1'($urandom);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mac_tx_en = 0; phy_rx_dv = 0; noise(); #1;
      chk_all(exp_loop);
    end
  endtask

  task automatic tx_frame(int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      mac_tx_en = 1; mac_txd = 4'($urandom); phy_rx_dv = 1'($urandom) & !exp_loop;
      noise(); #1;
      chk_all(exp_loop);
      if (exp_loop) chk("R5 crs span", {7'h0, mac_crs}, 8'h01);
    end
    @(negedge clk);
    mac_tx_en = 0; phy_rx_dv = 0; #1;
    chk_all(exp_loop);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    #12 rst_ni = 1;
    @(negedge clk); #1;
    chk_all(0); // R1 reset state normal
    idle(4);

    // R8: partial grants keep normal mode
    other_off = 1; manual = 0; lb_req = 1;
    idle(SYNC + 3);
    tx_frame(5);
    lb_req = 1; manual = 1; other_off = 0;
    idle(SYNC + 3);
    tx_frame(5);

    // R9: request while busy: switch deferred
    @(negedge clk); mac_tx_en = 1; phy_rx_dv = 0; mac_txd = 4'hA;
    other_off = 1; manual = 1; lb_req = 1;
    for (int i = 0; i < SYNC + 5; i++) begin
      @(negedge clk); mac_txd = 4'($urandom); noise(); #1;
      chk("R9 held normal dv", {7'h0, mac_rx_dv}, 8'h00);
    end
    @(negedge clk); mac_tx_en = 0;
    repeat (2) @(negedge clk);
    exp_loop = 1;
    idle(2);

    // R2 R4 R5: frames of several lengths
    tx_frame(1);
    tx_frame(2);
    tx_frame(17);
    for (int f = 0; f < 20; f++) begin
      tx_frame(1 + int'($urandom_range(0, 60)));
      idle(1 + int'($urandom_range(0, 3)));
    end

    // R9: drop request mid-frame, loop stays until quiet
    @(negedge clk); mac_tx_en = 1; lb_req = 0;
    for (int i = 0; i < SYNC + 5; i++) begin
      @(negedge clk); mac_txd = 4'($urandom); noise(); #1;
      chk("R9 held loop", {4'h0, mac_rxd}, {4'h0, mac_txd});
    end
    @(negedge clk); mac_tx_en = 0;
    repeat (2) @(negedge clk);
    exp_loop = 0;
    idle(2);

    // normal receive frames from PHY
    for (int f = 0; f < 10; f++) begin
      for (int i = 0; i < 1 + int'($urandom_range(0, 20)); i++) begin
        @(negedge clk); phy_rx_dv = 1; noise(); mac_txd = 4'($urandom); #1;
        chk_all(0);
      end
      idle(2);
    end

    // R8: other loopback turned back on blocks re-entry
    lb_req = 1; other_off = 0;
    idle(SYNC + 4);
    tx_frame(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule